// File: doc/BRIEF.md
# Scan-Chain Debug Register File with Word Mailbox

This block is a small debug register file that an external debugger reaches through one JTAG data-register chain. Each scan moves a 38-bit packet. The packet holds a 32-bit data word, a 5-bit register address and a direction flag. When the TAP reaches Update-DR, the packet is handed to the core clock domain. A write packet stores its data word in the addressed register. A read packet only records which register to read. The value read comes back in the data field of the next scan. The TAP controller sits outside the block and supplies the capture, shift and update strobes.

The register file contains:
- a debug control word, whose bit 4 selects monitor mode;
- a read-only debug status word that mirrors core status inputs;
- a vector-trap word;
- two watch units, each with six value/mask words for address, data and control;
- a 32-bit mailbox with one data word in each direction.

The mailbox control word reports the module version and two flags, one per direction. A debugger can poll these flags. Reading the mailbox data word consumes it. For that reason, the follow-up scan of a read should select the mailbox control word, because reading it has no side effect.

The TCK side and the core side exchange request and acknowledge toggles through two-flop synchronizers. The packet and the read data cross as buses that are held stable while the handshake is in flight. An access counts as done only when the acknowledge has come back to the TCK side.

Top module: `dbg_jtag_regchain`

## Requirements
- R1: The scan packet is 38 bits: bits 31:0 carry data, bits 36:32 the register address, and bit 37 the direction (1 = write, 0 = read). It is shifted in on `tdi` from bit 0 upward, and `tdo` presents bit 0 of the chain first.
- R2: A read packet only selects an address. The selected value is loaded into bits 31:0 at the Capture-DR of the next scan, and bits 37:32 capture as zero.
- R3: Address map and widths:
  - Address 0, debug control: 6 bits.
  - Address 1, debug status: read-only. It shows `stat_in` masked to 10 bits when VERSION >= 6, and to 5 bits otherwise.
  - Address 2, vector trap: 8 bits.
  - Addresses 8-13 (unit 0) and 16-21 (unit 1), watch registers: 32 bits each.
  - Bits that are not implemented read as zero, and writes to the status word are ignored.
- R4: The mailbox control word sits at address 4. Its bits 31:28 hold VERSION, bit 0 is the debugger-to-target pending flag, bit 1 is the target-to-debugger available flag, and every other bit reads zero. Writes to it are ignored.
- R5: A debugger write to address 5 stores the word on `tgt_rd_data` and sets `tgt_rx_full`. A `tgt_rd_pop` pulse clears the flag. If a write and a pop arrive in the same cycle, the write wins.
- R6: A `tgt_wr_push` pulse stores `tgt_wr_data` and sets `tgt_tx_full`. A debugger read of address 5 returns that word and clears the flag. Reading address 4 changes neither flag.
- R7: `dbg_ctrl` presents the debug control word. Its bit 4 is 1 for monitor mode and 0 for halting debug.
- R8: A write to an unmapped address changes no register, and a read from an unmapped address returns zero.
- R9: `acc_busy` rises at the TCK edge that accepts an update and stays high until the core acknowledge has passed back through the synchronizer. Update-DR strobes that arrive while `acc_busy` is high are ignored.
- R10: After reset, every register and flag is zero, `acc_busy` is low, and the first scan captures zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| capture_dr | input | 1 | Capture-DR strobe from the TAP |
| shift_dr | input | 1 | Shift-DR strobe from the TAP |
| update_dr | input | 1 | Update-DR strobe from the TAP |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| acc_busy | output | 1 | Access in flight between clock domains |
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| stat_in | input | 10 | Core status bits shown in the status word |
| dbg_ctrl | output | 6 | Debug control word (bit 4 = monitor mode) |
| tgt_rd_pop | input | 1 | Target consumes the debugger-to-target word |
| tgt_rd_data | output | 32 | Debugger-to-target word |
| tgt_rx_full | output | 1 | Debugger-to-target word pending |
| tgt_wr_push | input | 1 | Target posts a word for the debugger |
| tgt_wr_data | input | 32 | Word posted by the target |
| tgt_tx_full | output | 1 | Target-to-debugger word available |

## Verification
The assertions rely on three assumptions about the inputs:
- Capture-DR and Shift-DR are never active in the same TCK cycle.
- Both domains leave reset together.
- Target pushes and pops are single-cycle pulses in the core clock domain.

The stimulus respects these limits. It drives every TAP strobe at the falling TCK edge, one strobe at a time. It starts a new scan only after `acc_busy` has dropped, so the packet and read-data buses are stable whenever the other domain samples them. It pulses the target strobes only while no debugger access is in flight.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
    localparam int PKT_W        = 38;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 5;
    localparam int CTRL_W       = 6;
    localparam int STAT_MAX_W   = 10;
    localparam int VTRAP_W      = 8;
    localparam int WATCH_REGS   = 6;
    localparam int WATCH_BASE   = 8;
    localparam int WATCH_STRIDE = 8;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_pkt_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 5'd0,
        RA_STAT  = 5'd1,
        RA_VTRAP = 5'd2,
        RA_MCTRL = 5'd4,
        RA_MDATA = 5'd5
    } reg_addr_e;

    function automatic int stat_width(input int version);
        return (version >= 6) ? 10 : 5;
    endfunction

    function automatic logic [ADDR_W-1:0] watch_addr(input int unit, input int idx);
        return ADDR_W'(WATCH_BASE + unit * WATCH_STRIDE + idx);
    endfunction
endpackage

// File: rtl/dbgc_toggle_sync.sv
module dbgc_toggle_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dbgc_scan_chain.sv
module dbgc_scan_chain
    import dbgc_pkg::*;
(
    input  logic              tck,
    input  logic              tck_rst,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [DATA_W-1:0] rd_core,
    input  logic              ack_lvl,
    output logic              req_lvl,
    output scan_pkt_t         pkt_q,
    output logic              busy
);
    logic [PKT_W-1:0]  sr_q;
    logic [DATA_W-1:0] rd_tck_q;
    logic              ack_seen_q;
    logic              accept;

    assign busy   = req_lvl ^ ack_seen_q;
    assign accept = update_dr && !busy;
    assign tdo    = sr_q[0];

    always_ff @(posedge tck) begin
        if (tck_rst) begin
            sr_q       <= '0;
            pkt_q      <= '0;
            req_lvl    <= 1'b0;
            ack_seen_q <= 1'b0;
            rd_tck_q   <= '0;
        end else begin
            if (capture_dr)
                sr_q <= {{(PKT_W-DATA_W){1'b0}}, rd_tck_q};
            else if (shift_dr)
                sr_q <= {tdi, sr_q[PKT_W-1:1]};
            if (accept) begin
                pkt_q   <= scan_pkt_t'(sr_q);
                req_lvl <= ~req_lvl;
            end
            if (ack_lvl != ack_seen_q) begin
                ack_seen_q <= ack_lvl;
                rd_tck_q   <= rd_core;
            end
        end
    end

    AST_BUSY_RISE: assert property (@(posedge tck) disable iff (tck_rst)
        (update_dr && !busy) |=> busy); // R9
    AST_PKT_HELD: assert property (@(posedge tck) disable iff (tck_rst)
        busy |=> $stable(pkt_q)); // R9
endmodule

// File: rtl/dbgc_regfile.sv
module dbgc_regfile
    import dbgc_pkg::*;
#(
    parameter int VERSION     = 6,
    parameter int WATCH_UNITS = 2,
    parameter bit HAS_VTRAP   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_lvl,
    input  scan_pkt_t             pkt,
    output logic                  ack_lvl,
    output logic [DATA_W-1:0]     rd_q,
    input  logic [STAT_MAX_W-1:0] stat_in,
    output logic [CTRL_W-1:0]     dbg_ctrl,
    input  logic                  tgt_rd_pop,
    output logic [DATA_W-1:0]     tgt_rd_data,
    output logic                  tgt_rx_full,
    input  logic                  tgt_wr_push,
    input  logic [DATA_W-1:0]     tgt_wr_data,
    output logic                  tgt_tx_full
);
    localparam int STAT_W = stat_width(VERSION);
    localparam logic [STAT_MAX_W-1:0] STAT_MASK = STAT_MAX_W'((1 << STAT_W) - 1);

    logic                req_seen_q;
    logic                access, wr_en, rd_en;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [VTRAP_W-1:0]  vtrap_q;
    logic [DATA_W-1:0]   watch_q [WATCH_UNITS][WATCH_REGS];
    logic [DATA_W-1:0]   d2h_q;
    logic [DATA_W-1:0]   rd_mux;
    logic                mapped;

    assign access   = req_lvl != req_seen_q;
    assign wr_en    = access && pkt.wr;
    assign rd_en    = access && !pkt.wr;
    assign dbg_ctrl = ctrl_q;

    always_comb begin
        rd_mux = '0;
        mapped = 1'b0;
        case (pkt.addr)
            RA_CTRL:  begin rd_mux = DATA_W'(ctrl_q); mapped = 1'b1; end
            RA_STAT:  begin rd_mux = DATA_W'(stat_in & STAT_MASK); mapped = 1'b1; end
            RA_VTRAP: if (HAS_VTRAP) begin rd_mux = DATA_W'(vtrap_q); mapped = 1'b1; end
            RA_MCTRL: begin
                rd_mux = {4'(VERSION), 26'b0, tgt_tx_full, tgt_rx_full};
                mapped = 1'b1;
            end
            RA_MDATA: begin rd_mux = d2h_q; mapped = 1'b1; end
            default: ;
        endcase
        for (int u = 0; u < WATCH_UNITS; u++)
            for (int r = 0; r < WATCH_REGS; r++)
                if (pkt.addr == watch_addr(u, r)) begin
                    rd_mux = watch_q[u][r];
                    mapped = 1'b1;
                end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen_q <= 1'b0;
            ack_lvl    <= 1'b0;
            rd_q       <= '0;
        end else if (access) begin
            req_seen_q <= req_lvl;
            ack_lvl    <= ~ack_lvl;
            if (rd_en)
                rd_q <= rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            vtrap_q <= '0;
            for (int u = 0; u < WATCH_UNITS; u++)
                for (int r = 0; r < WATCH_REGS; r++)
                    watch_q[u][r] <= '0;
        end else if (wr_en) begin
            if (pkt.addr == RA_CTRL)
                ctrl_q <= pkt.data[CTRL_W-1:0];
            if (HAS_VTRAP && pkt.addr == RA_VTRAP)
                vtrap_q <= pkt.data[VTRAP_W-1:0];
            for (int u = 0; u < WATCH_UNITS; u++)
                for (int r = 0; r < WATCH_REGS; r++)
                    if (pkt.addr == watch_addr(u, r))
                        watch_q[u][r] <= pkt.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_rd_data <= '0;
            tgt_rx_full <= 1'b0;
        end else if (wr_en && pkt.addr == RA_MDATA) begin
            tgt_rd_data <= pkt.data;
            tgt_rx_full <= 1'b1;
        end else if (tgt_rd_pop) begin
            tgt_rx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d2h_q       <= '0;
            tgt_tx_full <= 1'b0;
        end else if (tgt_wr_push) begin
            d2h_q       <= tgt_wr_data;
            tgt_tx_full <= 1'b1;
        end else if (rd_en && pkt.addr == RA_MDATA) begin
            tgt_tx_full <= 1'b0;
        end
    end

    AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pkt.addr == RA_MDATA) |=> (tgt_rx_full && tgt_rd_data == $past(pkt.data))); // R5
    AST_TX_CONSUME: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pkt.addr == RA_MDATA && !tgt_wr_push) |=> !tgt_tx_full); // R6
    AST_MCTRL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pkt.addr == RA_MCTRL && !tgt_wr_push && !tgt_rd_pop)
        |=> ($stable(tgt_tx_full) && $stable(tgt_rx_full))); // R6
    AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pkt.addr == RA_MCTRL) |=> (rd_q[31:28] == 4'(VERSION))); // R4
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mapped) |=> (rd_q == '0)); // R8
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && pkt.addr == RA_CTRL) |=> $stable(dbg_ctrl)); // R7
endmodule

// File: rtl/dbg_jtag_regchain.sv
module dbg_jtag_regchain
    import dbgc_pkg::*;
#(
    parameter int VERSION     = 6,
    parameter int WATCH_UNITS = 2,
    parameter bit HAS_VTRAP   = 1'b1
) (
    input  logic        tck,
    input  logic        tck_rst,
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic        tdi,
    output logic        tdo,
    output logic        acc_busy,
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  stat_in,
    output logic [5:0]  dbg_ctrl,
    input  logic        tgt_rd_pop,
    output logic [31:0] tgt_rd_data,
    output logic        tgt_rx_full,
    input  logic        tgt_wr_push,
    input  logic [31:0] tgt_wr_data,
    output logic        tgt_tx_full
);
    logic              req_tck, req_core;
    logic              ack_core, ack_tck;
    scan_pkt_t         pkt;
    logic [DATA_W-1:0] rd_core;

    dbgc_scan_chain u_chain (
        .tck(tck), .tck_rst(tck_rst),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo),
        .rd_core(rd_core), .ack_lvl(ack_tck),
        .req_lvl(req_tck), .pkt_q(pkt), .busy(acc_busy)
    );

    dbgc_toggle_sync u_req_sync (.clk(clk), .rst(rst), .d(req_tck), .q(req_core));
    dbgc_toggle_sync u_ack_sync (.clk(tck), .rst(tck_rst), .d(ack_core), .q(ack_tck));

    dbgc_regfile #(
        .VERSION(VERSION), .WATCH_UNITS(WATCH_UNITS), .HAS_VTRAP(HAS_VTRAP)
    ) u_regs (
        .clk(clk), .rst(rst),
        .req_lvl(req_core), .pkt(pkt),
        .ack_lvl(ack_core), .rd_q(rd_core),
        .stat_in(stat_in), .dbg_ctrl(dbg_ctrl),
        .tgt_rd_pop(tgt_rd_pop), .tgt_rd_data(tgt_rd_data), .tgt_rx_full(tgt_rx_full),
        .tgt_wr_push(tgt_wr_push), .tgt_wr_data(tgt_wr_data), .tgt_tx_full(tgt_tx_full)
    );
endmodule

// File: tb/tb_dbg_jtag_regchain.sv
module tb_dbg_jtag_regchain;
    logic tck = 0, clk = 0;
    logic tck_rst = 1, rst = 1;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, acc_busy;
    logic [9:0]  stat_in = 10'h2D5;
    logic [5:0]  dbg_ctrl;
    logic        tgt_rd_pop = 0, tgt_wr_push = 0;
    logic [31:0] tgt_rd_data, tgt_wr_data = '0;
    logic        tgt_rx_full, tgt_tx_full;

    int checks = 0, errors = 0;
    logic busy_after_update;

    always #5  clk = ~clk;
    always #20 tck = ~tck;

    dbg_jtag_regchain dut (
        .tck(tck), .tck_rst(tck_rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .acc_busy(acc_busy),
        .clk(clk), .rst(rst), .stat_in(stat_in), .dbg_ctrl(dbg_ctrl),
        .tgt_rd_pop(tgt_rd_pop), .tgt_rd_data(tgt_rd_data), .tgt_rx_full(tgt_rx_full),
        .tgt_wr_push(tgt_wr_push), .tgt_wr_data(tgt_wr_data), .tgt_tx_full(tgt_tx_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [37:0] din, output logic [37:0] dout);
        @(negedge tck); capture_dr = 1;
        @(negedge tck); capture_dr = 0;
        for (int i = 0; i < 38; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            shift_dr = 1;
            @(negedge tck);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0;
        busy_after_update = acc_busy;
        for (int k = 0; k < 40 && acc_busy; k++) @(negedge tck);
        if (acc_busy) chk("R9 busy timeout", 32'(acc_busy), 32'd0);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] o;
        scan({1'b1, a, d}, o);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        logic [37:0] o;
        scan({1'b0, a, 32'h0}, o);
        scan({1'b0, 5'd4, 32'h0}, o);
        d = o[31:0];
    endtask

    function automatic logic [31:0] pat(input int a);
        return (32'h9E37_79B9 * 32'(a + 1)) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [31:0] expect_after_sweep(input int a);
        if (a == 0) return pat(a) & 32'h3F;
        if (a == 1) return 32'h2D5;
        if (a == 2) return pat(a) & 32'hFF;
        if (a == 4) return 32'h6000_0000;
        if ((a >= 8 && a <= 13) || (a >= 16 && a <= 21)) return pat(a);
        return 32'h0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [37:0] o;
        repeat (4) @(posedge tck);
        @(negedge tck); tck_rst = 0; rst = 0;
        repeat (2) @(negedge tck);

        // R10 reset state
        chk("R10 busy", 32'(acc_busy), 0);
        chk("R10 rx_full", 32'(tgt_rx_full), 0);
        chk("R10 tx_full", 32'(tgt_tx_full), 0);
        chk("R10 dbg_ctrl", 32'(dbg_ctrl), 0);
        scan({1'b0, 5'd0, 32'h0}, o);
        chk("R10 first capture", o[31:0], 0);
        scan({1'b0, 5'd4, 32'h0}, o);
        chk("R10 ctrl after reset", o[31:0], 0);
        rd(5'd4, v);
        chk("R4 mailbox ctrl reset", v, 32'h6000_0000);

        // R7 monitor mode, R9 busy
        wr(5'd0, 32'hFFFF_FFD5);
        chk("R9 busy after update", 32'(busy_after_update), 1);
        chk("R7 dbg_ctrl", 32'(dbg_ctrl), 32'h15);
        chk("R7 monitor bit", 32'(dbg_ctrl[4]), 1);

        // R2 / R1 split read: value surfaces on the next scan, upper bits zero
        wr(5'd2, 32'h0000_01A7);
        scan({1'b0, 5'd0, 32'hFFFF_FFFF}, o);
        scan({1'b0, 5'd2, 32'h0}, o);
        chk("R2 split read data", o[31:0], 32'h15);
        chk("R2 upper capture", 32'(o[37:32]), 0);
        scan({1'b0, 5'd4, 32'h0}, o);
        chk("R3 vtrap width", o[31:0], 32'hA7);

        wr(5'd0, 32'h0);
        chk("R7 halting mode", 32'(dbg_ctrl[4]), 0);

        // R3 / R8 sweep over every address except mailbox data
        for (int a = 0; a < 32; a++)
            if (a != 5) wr(5'(a), pat(a));
        for (int a = 0; a < 32; a++)
            if (a != 5) begin
                rd(5'(a), v);
                chk($sformatf("R3 R8 R4 addr %0d", a), v, expect_after_sweep(a));
            end
        chk("R8 rx untouched", 32'(tgt_rx_full), 0);

        // R5 debugger to target
        wr(5'd5, 32'h1234_5678);
        chk("R5 rx_full", 32'(tgt_rx_full), 1);
        chk("R5 rx data", tgt_rd_data, 32'h1234_5678);
        rd(5'd4, v);
        chk("R5 pending flag", v, 32'h6000_0001);
        @(negedge clk); tgt_rd_pop = 1;
        @(negedge clk); tgt_rd_pop = 0;
        @(negedge clk);
        chk("R5 pop clears", 32'(tgt_rx_full), 0);
        rd(5'd4, v);
        chk("R5 flag cleared", v, 32'h6000_0000);

        // R6 target to debugger
        @(negedge clk); tgt_wr_push = 1; tgt_wr_data = 32'hCAFE_F00D;
        @(negedge clk); tgt_wr_push = 0;
        @(negedge clk);
        chk("R6 tx_full", 32'(tgt_tx_full), 1);
        rd(5'd4, v);
        rd(5'd4, v);
        chk("R6 ctrl read no effect", v, 32'h6000_0002);
        chk("R6 flag kept", 32'(tgt_tx_full), 1);
        rd(5'd5, v);
        chk("R6 data read", v, 32'hCAFE_F00D);
        chk("R6 consumed", 32'(tgt_tx_full), 0);
        rd(5'd4, v);
        chk("R6 ctrl after consume", v, 32'h6000_0000);

        // R4 writes to mailbox control ignored
        wr(5'd4, 32'hFFFF_FFFF);
        rd(5'd4, v);
        chk("R4 write ignored", v, 32'h6000_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule